// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry and Return

This block is the control path of a small processor. It steps through its phases in a fixed pattern. It holds the program counter and the instruction register. It drives a one-word memory read port that uses a request/acknowledge handshake. When a fetch finishes, the block hands the instruction to an external execute stub. It then waits for the stub's done handshake. With that handshake the stub may supply a jump target or flag the instruction as a return from interrupt.

A dedicated interrupt-check phase follows every completed execute. If a request is pending and no handler is active, the sequencer does three things:
- It saves the program counter into a single shadow register and marks the handler as active, which masks further requests.
- It vectors the program counter to a fixed handler address.
- It resumes fetching at that address.

A return flag that arrives while the handler is active restores the saved program counter. It then clears the mask and resumes the interrupted program. The save and restore steps are exposed as one-cycle strobes, so that a context store elsewhere can follow them.

Phases and transitions: FETCH waits for an acknowledge and then goes to EXEC. EXEC waits for done and then goes to ICHK, or to RESTORE when the instruction is a return and the mask is set. ICHK goes to SAVE when an unmasked request is pending, and to FETCH otherwise. SAVE always goes to VECTOR. VECTOR and RESTORE both go to FETCH.

Top module: `icseq_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, the instruction register to 0 and the phase to FETCH, and clears the mask.
- R2: `mem_req` is high only in FETCH, with `mem_addr` equal to the program counter. FETCH holds, and nothing changes, until `mem_ack` is sampled high.
- R3: On a FETCH cycle with `mem_ack` high, the instruction register captures `mem_rdata`, the program counter increments by one and the next phase is EXEC.
- R4: EXEC holds until `ex_done`. On done with `ex_jump` high (and no taken return), the program counter is loaded with `ex_target`. The next phase is ICHK.
- R5: In ICHK, if `irq` is low or the mask is set, the next phase is FETCH and the program counter is unchanged.
- R6: In ICHK with `irq` high and the mask clear, the next phase is SAVE. SAVE pulses `save_ctx`, copies the program counter to the shadow register and sets the mask. It is followed by VECTOR, which loads `HANDLER_ADDR` into the program counter and then goes to FETCH.
- R7: `ex_done` with `ex_reti` high while the mask is set leads to RESTORE. Any `ex_jump` in that cycle is ignored. RESTORE pulses `restore_ctx`, loads the shadow value into the program counter, clears the mask and goes to FETCH.
- R8: `ex_reti` while the mask is clear has no effect. The instruction completes as an ordinary one (jump rule applies) and proceeds to ICHK.
- R9: `phase_o` encodes FETCH=0, EXEC=1, ICHK=2, SAVE=3, VECTOR=4, RESTORE=5. At most one of `mem_req`, `save_ctx`, `restore_ctx` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Instruction read request |
| mem_addr | output | AW | Read address (program counter) |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | DW | Read data |
| ex_done | input | 1 | Execute stub finished |
| ex_jump | input | 1 | Instruction supplies a new target |
| ex_target | input | AW | Jump target |
| ex_reti | input | 1 | Instruction is a return from interrupt |
| irq | input | 1 | Interrupt request level |
| ir_o | output | DW | Instruction register |
| pc_o | output | AW | Program counter |
| phase_o | output | 3 | Current phase code |
| save_ctx | output | 1 | Context save strobe |
| restore_ctx | output | 1 | Context restore strobe |
| irq_masked | output | 1 | Handler active, requests masked |

## Verification
Two of the block's functions can meet in one instruction's completion. A jump resolves in the same execute completion that precedes an interrupt check with `irq` high. The shadow must then hold the jump target, not the incremented address, so the later return resumes at the target. A second collision is a return flag arriving together with a jump, or together with a still-pending request. The return must win over the jump, and the request must not be taken until the restore has finished. Both cases are provoked by a directed script and then many times over by random stimulus. Every cycle is judged against a bench reference model of the phase, program counter, instruction register, mask and strobes.

// File: rtl/icseq_pkg.sv
package icseq_pkg;
    typedef enum logic [2:0] {
        PH_FETCH   = 3'd0,
        PH_EXEC    = 3'd1,
        PH_ICHK    = 3'd2,
        PH_SAVE    = 3'd3,
        PH_VECTOR  = 3'd4,
        PH_RESTORE = 3'd5
    } phase_t;
endpackage

// File: rtl/icseq_ctrl.sv
module icseq_ctrl
    import icseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mem_ack,
    input  logic   ex_done,
    input  logic   ex_jump,
    input  logic   ex_reti,
    input  logic   irq,
    input  logic   masked,
    output phase_t phase,
    output logic   mem_req,
    output logic   load_ir,
    output logic   jump_en,
    output logic   save_en,
    output logic   vec_en,
    output logic   rest_en
);
    phase_t nxt;
    logic   reti_taken;

    assign reti_taken = ex_reti && masked;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FETCH;
        else     phase <= nxt;
    end

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_FETCH:   if (mem_ack) nxt = PH_EXEC;
            PH_EXEC:    if (ex_done) nxt = reti_taken ? PH_RESTORE : PH_ICHK;
            PH_ICHK:    nxt = (irq && !masked) ? PH_SAVE : PH_FETCH;
            PH_SAVE:    nxt = PH_VECTOR;
            PH_VECTOR:  nxt = PH_FETCH;
            PH_RESTORE: nxt = PH_FETCH;
            default:    nxt = PH_FETCH;
        endcase
    end

    always_comb begin
        mem_req = (phase == PH_FETCH);
        load_ir = (phase == PH_FETCH) && mem_ack;
        jump_en = (phase == PH_EXEC) && ex_done && ex_jump && !reti_taken;
        save_en = (phase == PH_SAVE);
        vec_en  = (phase == PH_VECTOR);
        rest_en = (phase == PH_RESTORE);
    end

    // R2: fetch waits for acknowledge
    a_r2_fetch_holds: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && !mem_ack) |=> (phase == PH_FETCH));

    // R5: no pending or masked request returns to fetch
    a_r5_ichk_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ICHK && (!irq || masked)) |=> (phase == PH_FETCH));

    // R6: save is followed by vector with the mask now set
    a_r6_save_then_vector: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SAVE) |=> (phase == PH_VECTOR && masked));

    // R7: a taken return skips the interrupt check
    a_r7_reti_to_restore: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && ex_done && ex_reti && masked) |=> (phase == PH_RESTORE));

    // R9: port strobes never overlap
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, save_en, rest_en}));
endmodule

// File: rtl/icseq_regs.sv
module icseq_regs #(
    parameter int AW           = 12,
    parameter int DW           = 16,
    parameter int HANDLER_ADDR = 'h100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_ir,
    input  logic          jump_en,
    input  logic          save_en,
    input  logic          vec_en,
    input  logic          rest_en,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] ex_target,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic          masked
);
    localparam logic [AW-1:0] VEC = AW'(HANDLER_ADDR);

    logic [AW-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            shadow <= '0;
            masked <= 1'b0;
        end else begin
            if (load_ir) begin
                ir <= mem_rdata;
                pc <= pc + 1'b1;
            end
            if (jump_en) pc <= ex_target;
            if (save_en) begin
                shadow <= pc;
                masked <= 1'b1;
            end
            if (vec_en) pc <= VEC;
            if (rest_en) begin
                pc     <= shadow;
                masked <= 1'b0;
            end
        end
    end

    // R3: fetch completion captures data and increments
    a_r3_capture_incr: assert property (@(posedge clk) disable iff (rst)
        load_ir |=> (pc == $past(pc) + 1'b1 && ir == $past(mem_rdata)));

    // R4: jump loads the supplied target
    a_r4_jump_target: assert property (@(posedge clk) disable iff (rst)
        jump_en |=> (pc == $past(ex_target)));

    // R6: vectoring lands on the handler address
    a_r6_vector_addr: assert property (@(posedge clk) disable iff (rst)
        vec_en |=> (pc == VEC));

    // R7: restore brings back the saved counter and unmasks
    a_r7_restore_pc: assert property (@(posedge clk) disable iff (rst)
        rest_en |=> (pc == $past(shadow) && !masked));
endmodule

// File: rtl/icseq_top.sv
module icseq_top
    import icseq_pkg::*;
#(
    parameter int AW           = 12,
    parameter int DW           = 16,
    parameter int HANDLER_ADDR = 'h100
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ex_done,
    input  logic          ex_jump,
    input  logic [AW-1:0] ex_target,
    input  logic          ex_reti,
    input  logic          irq,
    output logic [DW-1:0] ir_o,
    output logic [AW-1:0] pc_o,
    output logic [2:0]    phase_o,
    output logic          save_ctx,
    output logic          restore_ctx,
    output logic          irq_masked
);
    phase_t        phase;
    logic          load_ir, jump_en, save_en, vec_en, rest_en;
    logic [AW-1:0] pc;

    icseq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mem_ack (mem_ack),
        .ex_done (ex_done),
        .ex_jump (ex_jump),
        .ex_reti (ex_reti),
        .irq     (irq),
        .masked  (irq_masked),
        .phase   (phase),
        .mem_req (mem_req),
        .load_ir (load_ir),
        .jump_en (jump_en),
        .save_en (save_en),
        .vec_en  (vec_en),
        .rest_en (rest_en)
    );

    icseq_regs #(
        .AW           (AW),
        .DW           (DW),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_ir   (load_ir),
        .jump_en   (jump_en),
        .save_en   (save_en),
        .vec_en    (vec_en),
        .rest_en   (rest_en),
        .mem_rdata (mem_rdata),
        .ex_target (ex_target),
        .pc        (pc),
        .ir        (ir_o),
        .masked    (irq_masked)
    );

    assign mem_addr    = pc;
    assign pc_o        = pc;
    assign phase_o     = phase;
    assign save_ctx    = save_en;
    assign restore_ctx = rest_en;
endmodule

// File: tb/tb_icseq_top.sv
`timescale 1ns/1ps
module tb_icseq_top;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int HADDR = 'h100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_req, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          ex_done = 1'b0, ex_jump = 1'b0, ex_reti = 1'b0, irq = 1'b0;
    logic [AW-1:0] ex_target = '0;
    logic [DW-1:0] ir_o;
    logic [AW-1:0] pc_o;
    logic [2:0]    phase_o;
    logic          save_ctx, restore_ctx, irq_masked;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [2:0]    m_ph = 3'd0;
    logic [AW-1:0] m_pc = '0, m_sh = '0;
    logic [DW-1:0] m_ir = '0;
    logic          m_msk = 1'b0;

    always #2 clk = ~clk;

    icseq_top #(.AW(AW), .DW(DW), .HANDLER_ADDR(HADDR)) dut (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ex_done(ex_done),
        .ex_jump(ex_jump), .ex_target(ex_target), .ex_reti(ex_reti),
        .irq(irq), .ir_o(ir_o), .pc_o(pc_o), .phase_o(phase_o),
        .save_ctx(save_ctx), .restore_ctx(restore_ctx), .irq_masked(irq_masked)
    );

    function automatic logic [DW-1:0] rdf(input logic [AW-1:0] a);
        return DW'(a) * 16'h3B1 ^ 16'hA55A;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R9", "phase", int'(phase_o), int'(m_ph));
        chk("R4", "pc", int'(pc_o), int'(m_pc));
        chk("R3", "ir", int'(ir_o), int'(m_ir));
        chk("R6", "mask", int'(irq_masked), int'(m_msk));
        chk("R2", "mem_req", int'(mem_req), int'(m_ph == 3'd0));
        if (mem_req) chk("R2", "mem_addr", int'(mem_addr), int'(m_pc));
        chk("R6", "save_ctx", int'(save_ctx), int'(m_ph == 3'd3));
        chk("R7", "restore_ctx", int'(restore_ctx), int'(m_ph == 3'd5));
    endtask

    // one cycle: check at negedge, drive inputs, advance model
    task automatic step(input logic i_irq, input logic i_ack, input logic i_done,
                        input logic i_jmp, input logic [AW-1:0] tgt, input logic i_reti);
        compare_all();
        irq = i_irq; mem_ack = i_ack; ex_done = i_done;
        ex_jump = i_jmp; ex_target = tgt; ex_reti = i_reti;
        mem_rdata = rdf(m_pc);
        case (m_ph)
            3'd0: if (i_ack) begin m_ir = rdf(m_pc); m_pc = m_pc + 1'b1; m_ph = 3'd1; end
            3'd1: if (i_done) begin
                if (i_reti && m_msk) m_ph = 3'd5;        // R7
                else begin                               // R8 when reti unmasked
                    if (i_jmp) m_pc = tgt;
                    m_ph = 3'd2;
                end
            end
            3'd2: m_ph = (i_irq && !m_msk) ? 3'd3 : 3'd0;
            3'd3: begin m_sh = m_pc; m_msk = 1'b1; m_ph = 3'd4; end
            3'd4: begin m_pc = AW'(HADDR); m_ph = 3'd0; end
            3'd5: begin m_pc = m_sh; m_msk = 1'b0; m_ph = 3'd0; end
            default: m_ph = 3'd0;
        endcase
        @(negedge clk);
    endtask

    task automatic run_all();
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "reset pc", int'(pc_o), 0);
        chk("R1", "reset phase", int'(phase_o), 0);
        chk("R1", "reset mask", int'(irq_masked), 0);
        chk("R1", "reset ir", int'(ir_o), 0);
        // directed script
        step(0, 0, 0, 0, '0, 0);          // R2 fetch waits
        step(1, 0, 1, 0, '0, 0);          // R2 done/irq ignored in fetch
        step(0, 1, 0, 0, '0, 0);          // R3 ack -> EXEC
        step(1, 0, 0, 1, 12'h555, 1);     // R4 exec holds without done
        step(0, 0, 1, 1, 12'h234, 1);     // R8 reti unmasked ignored, R4 jump
        step(1, 0, 0, 0, '0, 0);          // R6 irq at ICHK -> SAVE (shadow gets jump target)
        step(0, 0, 0, 0, '0, 0);          // SAVE
        step(0, 0, 0, 0, '0, 0);          // VECTOR
        step(0, 1, 0, 0, '0, 0);          // fetch at handler
        step(1, 0, 1, 0, '0, 0);          // exec done with irq pending
        step(1, 0, 0, 0, '0, 0);          // R5 masked irq -> FETCH
        step(1, 1, 0, 0, '0, 0);
        step(1, 0, 1, 1, 12'h777, 1);     // R7 reti wins over jump and irq
        step(1, 0, 0, 0, '0, 0);          // RESTORE
        step(1, 0, 0, 0, '0, 0);          // FETCH at 0x234
        chk("R7", "resume pc", int'(pc_o), 'h234);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 100) < 35, ($urandom % 100) < 50,
                 ($urandom % 100) < 40, ($urandom % 100) < 30,
                 AW'($urandom), ($urandom % 100) < 25);
        end
        compare_all();
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run_all();
            begin #600000; timed_out = 1'b1; end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule